// File: doc/BRIEF.md
# In-Order Pipeline Hazard Stall Controller

This block is the sequencing logic of a four-stage in-order pipeline whose stages are fetch, decode, execute and write. Instructions arrive one at a time over a valid/ready stream. Each carries an operation class, a destination register, two source registers and a sequence tag. No results are computed. The block only decides, cycle by cycle, which stages move forward and which hold. Execute time is modelled with a down-counter.

Three kinds of hazard stop the flow. A source that names the destination of an older instruction still in execute blocks issue. The single divider holds the execute stage for several cycles. A branch blocks any further fetch until the branch has written back. A hold in any stage holds every younger stage behind it in the same cycle. Instructions therefore complete strictly in program order, and each completion is marked by a one-cycle retire pulse that carries the tag.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: Each stage holds at most one instruction. `stage_vld` bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 write. An instruction accepted at a clock edge sits in fetch for the following cycle. With no hazards, it is in decode one cycle later, in execute two cycles later and in write three cycles later.
- R2: An instruction of the divide class stays in execute for DIV_LAT consecutive cycles (2 by default). Every other class stays for one cycle.
- R3: Instructions enter execute in program order. An instruction enters only in the cycle after the previous occupant's last execute cycle. Two independent divides therefore never overlap in execute.
- R4: An instruction in decode whose source register equals the destination of an instruction still in execute waits in decode. It enters execute in the cycle after the producer's last execute cycle. Register 0 never causes a wait, and branches mark no destination.
- R5: A stage that holds a valid instruction without passing it on raises its bit in `stage_stall`, using the same bit positions as R1. A held decode stage also holds fetch, and `in_ready` stays low while fetch cannot take a new instruction. The write stage never stalls.
- R6: After a branch is accepted, `in_ready` stays low until the cycle in which that branch is in write. The next instruction is therefore in fetch in the cycle right after the branch's write cycle.
- R7: `retire_valid` is high for exactly one cycle per instruction, in its write cycle. `retire_tag` then equals the tag the instruction was accepted with, so tags come out in acceptance order.
- R8: Class encoding: 0 is ALU, 1 is divide, 2 is branch. Code 3 behaves exactly like ALU.
- R9: A synchronous active-high `rst` empties all stages, clears all busy registers and clears a pending branch. After reset, `in_ready` is high and no stage is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Fetch stage can take the offered instruction |
| in_cls | input | 2 | Operation class (R8 encoding) |
| in_dst | input | REG_W | Destination register |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| in_tag | input | TAG_W | Sequence tag |
| stage_vld | output | 4 | Per-stage occupancy |
| stage_stall | output | 4 | Per-stage hold indication |
| retire_valid | output | 1 | Write-stage pulse |
| retire_tag | output | TAG_W | Tag of the retiring instruction |

## Verification
The bench builds the block with its defaults: eight registers, 8-bit tags and a two-cycle divide. With these values, every ordering of ALU, divide and branch over four-instruction programs can be swept in a short run. For each program, the bench derives fetch, decode, issue and write cycles from a recurrence on the timing rules. It compares the stage vectors every cycle, and it checks the acceptance cycle of every instruction and the cycle and tag of every retire. Directed programs cover dependent and independent divides, back-to-back branches, class code 3, register 0, and a reset taken while a branch is pending.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_DIV = 2'd1,
    CLS_BR  = 2'd2,
    CLS_ALT = 2'd3
  } op_cls_e;

  // Execute occupancy in cycles for a class.
  function automatic int unsigned exec_len(op_cls_e c, int unsigned div_lat);
    return (c == CLS_DIV) ? div_lat : 1;
  endfunction

  // Whether the class produces a register result.
  function automatic logic writes_reg(op_cls_e c);
    return c != CLS_BR;
  endfunction

  function automatic logic is_branch(op_cls_e c);
    return c == CLS_BR;
  endfunction

endpackage

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0] chk_a,
  input  logic [REG_W-1:0] chk_b,
  output logic             blocked
);

  logic [NUM_REGS-1:0] busy;
  logic [NUM_REGS-1:0] live;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign busy[g] = 1'b0;
    end else begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (rst)                                      q <= 1'b0;
        else if (set_en && set_reg == REG_W'(g))      q <= 1'b1;
        else if (clr_en && clr_reg == REG_W'(g))      q <= 1'b0;
      end
      assign busy[g] = q;
    end
    // A register whose producer finishes this cycle no longer blocks.
    assign live[g] = busy[g] && !(clr_en && clr_reg == REG_W'(g));
  end

  assign blocked = live[chk_a] || live[chk_b];

  assert_busy_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (set_en && set_reg != '0) |=> busy[$past(set_reg)]);

  assert_busy_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_reg != '0 && !(set_en && set_reg == clr_reg)) |=> !busy[$past(clr_reg)]);

endmodule

// File: rtl/hz_exec_slot.sv
module hz_exec_slot
  import hz_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned TAG_W    = 8,
  parameter int unsigned DIV_LAT  = 2,
  localparam int unsigned REG_W = $clog2(NUM_REGS),
  localparam int unsigned CNT_W = $clog2(DIV_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  op_cls_e          in_cls,
  input  logic [REG_W-1:0] in_dst,
  input  logic [TAG_W-1:0] in_tag,
  output logic             e_vld,
  output op_cls_e          e_cls,
  output logic [REG_W-1:0] e_dst,
  output logic [TAG_W-1:0] e_tag,
  output logic             e_done,
  output logic             e_free
);

  logic [CNT_W-1:0] left;

  assign e_done = e_vld && (left == '0);
  assign e_free = !e_vld || e_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld <= 1'b0;
      left  <= '0;
      e_cls <= CLS_ALU;
      e_dst <= '0;
      e_tag <= '0;
    end else if (issue) begin
      e_vld <= 1'b1;
      left  <= CNT_W'(exec_len(in_cls, DIV_LAT) - 1);
      e_cls <= in_cls;
      e_dst <= in_dst;
      e_tag <= in_tag;
    end else if (e_done) begin
      e_vld <= 1'b0;
    end else if (e_vld) begin
      left <= left - 1'b1;
    end
  end

  assert_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (issue && in_cls != CLS_DIV) |=> e_done);

  if (DIV_LAT > 1) begin : g_multi
    assert_div_holds_R2: assert property (@(posedge clk) disable iff (rst)
      (issue && in_cls == CLS_DIV) |=> (e_vld && !e_done && e_cls == CLS_DIV));
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    (e_vld && !e_done) |-> !issue);

endmodule

// File: rtl/hz_fetch_gate.sv
module hz_fetch_gate
  import hz_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    accept,
  input  op_cls_e accept_cls,
  input  logic    wb_vld,
  input  op_cls_e wb_cls,
  output logic    fetch_block
);

  logic br_pend;
  logic wb_br;

  assign wb_br       = wb_vld && is_branch(wb_cls);
  // The write cycle of the branch already lets the next fetch in.
  assign fetch_block = br_pend && !wb_br;

  always_ff @(posedge clk) begin
    if (rst)                                   br_pend <= 1'b0;
    else if (accept && is_branch(accept_cls))  br_pend <= 1'b1;
    else if (wb_br)                            br_pend <= 1'b0;
  end

  assert_no_fetch_behind_branch_R6: assert property (@(posedge clk) disable iff (rst)
    (br_pend && !wb_br) |-> !accept);

  assert_branch_arms_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && is_branch(accept_cls)) |=> br_pend);

endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned TAG_W    = 8,
  parameter int unsigned DIV_LAT  = 2,
  localparam int unsigned REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_cls,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic [TAG_W-1:0] in_tag,
  output logic [3:0]       stage_vld,
  output logic [3:0]       stage_stall,
  output logic             retire_valid,
  output logic [TAG_W-1:0] retire_tag
);

  // fetch stage
  logic             f_vld;
  op_cls_e          f_cls;
  logic [REG_W-1:0] f_dst, f_sa, f_sb;
  logic [TAG_W-1:0] f_tag;
  // decode stage
  logic             d_vld;
  op_cls_e          d_cls;
  logic [REG_W-1:0] d_dst, d_sa, d_sb;
  logic [TAG_W-1:0] d_tag;
  // execute stage (in slot)
  logic             e_vld, e_done, e_free;
  op_cls_e          e_cls;
  logic [REG_W-1:0] e_dst;
  logic [TAG_W-1:0] e_tag;
  // write stage
  logic             w_vld;
  op_cls_e          w_cls;
  logic [TAG_W-1:0] w_tag;

  // named events
  logic sb_block, fetch_block;
  logic issue, d_take, f_move, f_room, accept;
  op_cls_e in_cls_e;

  assign in_cls_e = op_cls_e'(in_cls);
  assign issue    = d_vld && e_free && !sb_block;
  assign d_take   = !d_vld || issue;
  assign f_move   = f_vld && d_take;
  assign f_room   = !f_vld || f_move;
  assign in_ready = f_room && !fetch_block;
  assign accept   = in_valid && in_ready;

  hz_fetch_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .accept_cls  (in_cls_e),
    .wb_vld      (w_vld),
    .wb_cls      (w_cls),
    .fetch_block (fetch_block)
  );

  hz_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
    .clk     (clk),
    .rst     (rst),
    .set_en  (issue && writes_reg(d_cls)),
    .set_reg (d_dst),
    .clr_en  (e_done && writes_reg(e_cls)),
    .clr_reg (e_dst),
    .chk_a   (d_sa),
    .chk_b   (d_sb),
    .blocked (sb_block)
  );

  hz_exec_slot #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DIV_LAT(DIV_LAT)) u_exec (
    .clk    (clk),
    .rst    (rst),
    .issue  (issue),
    .in_cls (d_cls),
    .in_dst (d_dst),
    .in_tag (d_tag),
    .e_vld  (e_vld),
    .e_cls  (e_cls),
    .e_dst  (e_dst),
    .e_tag  (e_tag),
    .e_done (e_done),
    .e_free (e_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f_vld <= 1'b0; f_cls <= CLS_ALU; f_dst <= '0; f_sa <= '0; f_sb <= '0; f_tag <= '0;
    end else if (f_room) begin
      f_vld <= accept;
      if (accept) begin
        f_cls <= in_cls_e; f_dst <= in_dst; f_sa <= in_src_a; f_sb <= in_src_b; f_tag <= in_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_vld <= 1'b0; d_cls <= CLS_ALU; d_dst <= '0; d_sa <= '0; d_sb <= '0; d_tag <= '0;
    end else if (d_take) begin
      d_vld <= f_move;
      if (f_move) begin
        d_cls <= f_cls; d_dst <= f_dst; d_sa <= f_sa; d_sb <= f_sb; d_tag <= f_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_vld <= 1'b0; w_cls <= CLS_ALU; w_tag <= '0;
    end else begin
      w_vld <= e_done;
      w_cls <= e_cls;
      w_tag <= e_tag;
    end
  end

  assign stage_vld    = {w_vld, e_vld, d_vld, f_vld};
  assign stage_stall  = {1'b0, e_vld && !e_done, d_vld && !issue, f_vld && !f_move};
  assign retire_valid = w_vld;
  assign retire_tag   = w_tag;

  assert_held_fetch_keeps_tag_R5: assert property (@(posedge clk) disable iff (rst)
    (f_vld && !f_move) |=> (f_vld && f_tag == $past(f_tag)));

  assert_held_decode_keeps_tag_R5: assert property (@(posedge clk) disable iff (rst)
    (d_vld && !issue) |=> (d_vld && d_tag == $past(d_tag)));

  assert_retire_after_exec_R7: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> $past(stage_vld[2]));

  assert_reset_clears_R9: assert property (@(posedge clk)
    $past(rst) |-> (stage_vld == 4'b0 && !retire_valid && in_ready));

endmodule

// File: tb/hz_pipe_ctrl_bench.sv
module hz_pipe_ctrl_bench;
  localparam int NR = 8;
  localparam int TW = 8;
  localparam int DL = 2;
  localparam int RW = $clog2(NR);
  localparam int MAXN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_cls = '0;
  logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [TW-1:0] in_tag = '0;
  logic [3:0] stage_vld, stage_stall;
  logic retire_valid;
  logic [TW-1:0] retire_tag;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int tagc = 0;
  int p_cls[MAXN], p_dst[MAXN], p_sa[MAXN], p_sb[MAXN], p_gap[MAXN];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hz_pipe_ctrl #(.NUM_REGS(NR), .TAG_W(TW), .DIV_LAT(DL)) u_hz_pipe_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_tag(in_tag), .stage_vld(stage_vld), .stage_stall(stage_stall),
    .retire_valid(retire_valid), .retire_tag(retire_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: act=%0d exp=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic put(input int k, input int c, input int d, input int a, input int b, input int g);
    p_cls[k] = c; p_dst[k] = d; p_sa[k] = a; p_sb[k] = b; p_gap[k] = g;
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Runs p_* [0..n-1]; timing derived from the requirement rules.
  task automatic run_prog(input int n, input string lbl);
    int a[MAXN], d[MAXN], x[MAXN], w[MAXN], e[MAXN];
    int base, brw, i, r, tag0;
    logic [3:0] ev, es;
    @(negedge clk);
    base = cyc;
    brw  = -100;
    tag0 = tagc;
    for (int k = 0; k < n; k++) begin
      int ln;
      ln   = (p_cls[k] == 1) ? DL : 1;
      e[k] = ((k == 0) ? base + 1 : a[k-1] + 1) + p_gap[k];
      a[k] = mx(e[k], brw + 1);
      if (k > 0) a[k] = mx(a[k], d[k-1]);
      d[k] = a[k] + 1;
      if (k > 0) d[k] = mx(d[k], x[k-1]);
      x[k] = d[k] + 1;
      if (k > 0) x[k] = mx(x[k], x[k-1] + ((p_cls[k-1] == 1) ? DL : 1));
      w[k] = x[k] + ln;
      if (p_cls[k] == 2) brw = w[k];
    end
    i = 0; r = 0;
    while (r < n) begin
      ev = '0; es = '0;
      for (int k = 0; k < n; k++) begin
        if (cyc >= a[k] && cyc < d[k]) begin ev[0] = 1'b1; if (cyc < d[k] - 1) es[0] = 1'b1; end
        if (cyc >= d[k] && cyc < x[k]) begin ev[1] = 1'b1; if (cyc < x[k] - 1) es[1] = 1'b1; end
        if (cyc >= x[k] && cyc < w[k]) begin ev[2] = 1'b1; if (cyc < w[k] - 1) es[2] = 1'b1; end
        if (cyc == w[k]) ev[3] = 1'b1;
      end
      chk(stage_vld == ev, {"R1 stage_vld ", lbl}, int'(stage_vld), int'(ev));
      chk(stage_stall == es, {"R5 stage_stall ", lbl}, int'(stage_stall), int'(es));
      chk(retire_valid == (cyc == w[r]), {"R7 retire timing ", lbl}, int'(retire_valid), int'(cyc == w[r]));
      if (retire_valid) begin
        chk(retire_tag == TW'(tag0 + r), "R7 retire tag", int'(retire_tag), int'(TW'(tag0 + r)));
        r++;
      end
      if (i < n && cyc + 1 >= e[i]) begin
        in_valid = 1'b1;
        in_cls   = 2'(p_cls[i]);
        in_dst   = RW'(p_dst[i]);
        in_src_a = RW'(p_sa[i]);
        in_src_b = RW'(p_sb[i]);
        in_tag   = TW'(tag0 + i);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (in_valid && in_ready) begin
        chk(cyc + 1 == a[i], {"R6 accept cycle ", lbl}, cyc + 1, a[i]);
        i++;
      end
      @(negedge clk);
      if (cyc - base > 300) begin
        chk(1'b0, {"R1 program stuck ", lbl}, r, n);
        break;
      end
    end
    in_valid = 1'b0;
    tagc = tagc + n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog expired: act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(stage_vld == 4'b0, "R9 reset stage_vld", int'(stage_vld), 0);
    chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
    chk(retire_valid == 1'b0, "R9 reset retire", int'(retire_valid), 0);
    rst = 1'b0;

    // dependent divide chain followed by a branch (R4)
    put(0, 1, 2, 1, 1, 0); put(1, 0, 3, 2, 0, 0); put(2, 2, 0, 3, 3, 0); put(3, 0, 4, 0, 0, 0);
    run_prog(4, "R4");
    // two independent divides share the one divider (R3)
    put(0, 1, 1, 5, 5, 0); put(1, 1, 2, 6, 6, 0); put(2, 0, 3, 7, 7, 0);
    run_prog(3, "R3");
    // register 0 as destination and source (R4)
    put(0, 1, 0, 4, 4, 0); put(1, 0, 5, 0, 0, 0); put(2, 1, 6, 0, 5, 0);
    run_prog(3, "R4");
    // back-to-back branches (R6)
    put(0, 2, 1, 2, 3, 0); put(1, 2, 0, 1, 1, 0); put(2, 0, 1, 1, 1, 0);
    run_prog(3, "R6");
    // class code 3 behaves as ALU (R8)
    put(0, 3, 1, 0, 0, 0); put(1, 3, 2, 1, 1, 0); put(2, 1, 3, 2, 2, 0); put(3, 3, 4, 3, 3, 0);
    run_prog(4, "R8");
    // full-throughput ALU stream (R1)
    for (int k = 0; k < 12; k++) put(k, 0, (k % 7) + 1, ((k + 3) % 7) + 1, 0, 0);
    run_prog(12, "R1");

    // divide latency sweep over all class orderings (R2)
    for (int c = 0; c < 81; c++) begin
      for (int k = 0; k < 4; k++) begin
        int cl, dv;
        dv = c;
        for (int j = 0; j < k; j++) dv = dv / 3;
        cl = dv % 3;
        put(k, cl, (c + k) % NR, (k > 0 && (c % 2 == 0)) ? (c + k - 1) % NR : 7,
            (c + 2 * k) % NR, (k > 0 && (c % 5 == k)) ? 1 : 0);
      end
      run_prog(4, "R2");
    end

    // reset while a branch is pending (R9)
    @(negedge clk);
    in_valid = 1'b1; in_cls = 2'd2; in_dst = '0; in_src_a = '0; in_src_b = '0; in_tag = TW'(tagc);
    @(negedge clk);
    in_cls = 2'd0;
    #1;
    chk(in_ready == 1'b0, "R6 ready low behind branch", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(stage_vld == 4'b0, "R9 mid-run reset stage_vld", int'(stage_vld), 0);
    chk(in_ready == 1'b1, "R9 mid-run reset in_ready", int'(in_ready), 1);
    rst = 1'b0;
    tagc = tagc + 1;
    put(0, 0, 1, 0, 0, 0); put(1, 1, 2, 1, 1, 0);
    run_prog(2, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule